// File: doc/BRIEF.md
# Video Memory Block-Transfer Engine

This block moves data into the memories of a video controller without the host processor taking part, one element per step. It runs in three modes. The first fetches 16-bit words from system memory over a request/acknowledge read port and writes them into video RAM, colour RAM or vertical-scroll RAM. The second copies single bytes from one place in video RAM to another. The third fills a run of video RAM with one byte value. All three modes share one length counter, one destination address register and one source counter.

A controller starts an operation with a one-cycle start pulse. The pulse carries the mode, the destination target, the start address, the per-step address increment, the three source segments and the length. A fill operation then waits until the data port supplies the fill byte. While the engine works, `busy_o` stays high. When the last element has been written, `done_o` pulses for one cycle. Bus arbitration, slot timing and the RAM arrays themselves sit outside this block.

Top module: `vdma_engine`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `sys_req_o`, `vram_rd_o` and all three write enables are low.
- R2: In system mode (`mode_i[1]`=0), `sys_addr_o` is {hi[6:0], mid[7:0], lo[7:0], 1'b0}. After each acknowledged word, lo increments. When lo wraps from 0xFF, mid increments. hi never changes during an operation.
- R3: In system mode, `target_i` picks the destination of each acknowledged word. A value of 0 writes a video RAM word at `addr[15:1]` with `vram_be_o`=2'b11. A value of 1 writes colour RAM at `addr[6:1]`. A value of 2 writes scroll RAM at `addr[6:1]`. The written data is `sys_data_i`, and at most one write enable is high at a time.
- R4: In system mode with target 0 and an odd address, the word is dropped: no write enable rises. The address, the source and the count still advance.
- R5: In copy mode (`mode_i`=2'b11), `vram_rd_addr_o` is {mid, lo}. The byte returned on `vram_rd_data_i` one cycle later is written with `wdata_o`={b,b}. The write uses `vram_be_o`=2'b01 (low lane) when the destination address is odd and 2'b10 (high lane) when it is even.
- R6: In fill mode (`mode_i`=2'b10), the fill byte b is written with `wdata_o`={b,b}. The write uses `vram_be_o`=2'b01 when the address is even and 2'b10 when it is odd, at word address `addr[15:1]`.
- R7: After every transfer, the destination address grows by `incr_i` modulo 2^16.
- R8: An operation performs exactly `len_i` transfers. A length of 0 performs 65536 transfers.
- R9: A fill writes nothing until `fill_wr_i` delivers the fill byte on `fill_data_i`.
- R10: `busy_o` is high from the cycle after an accepted start until the last transfer. `done_o` is high for exactly the one cycle after the last transfer, and in that cycle `busy_o` is already low.
- R11: A start pulse while `busy_o` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted when idle |
| mode_i | input | 2 | 0x system, 10 fill, 11 copy |
| target_i | input | 2 | System-mode destination: 0 video, 1 colour, 2 scroll |
| dest_addr_i | input | 16 | Start destination byte address |
| incr_i | input | 8 | Address increment per transfer |
| src_lo_i | input | 8 | Source low segment |
| src_mid_i | input | 8 | Source middle segment |
| src_hi_i | input | 7 | Source high segment |
| len_i | input | 16 | Transfer count, 0 means 65536 |
| fill_wr_i | input | 1 | Data-port write carrying the fill byte |
| fill_data_i | input | 8 | Fill byte |
| sys_req_o | output | 1 | System-memory word read request |
| sys_addr_o | output | 24 | System-memory byte address |
| sys_ack_i | input | 1 | Read acknowledge, data valid |
| sys_data_i | input | 16 | System-memory read data |
| vram_rd_o | output | 1 | Video RAM byte read (copy mode) |
| vram_rd_addr_o | output | 16 | Video RAM read byte address |
| vram_rd_data_i | input | 8 | Read byte, valid one cycle after the read |
| vram_we_o | output | 1 | Video RAM write enable |
| vram_waddr_o | output | 15 | Video RAM word address |
| vram_be_o | output | 2 | Lane enables, bit 1 high byte |
| wdata_o | output | 16 | Write data for all three RAMs |
| cram_we_o | output | 1 | Colour RAM write enable |
| cram_addr_o | output | 6 | Colour RAM word address |
| vsram_we_o | output | 1 | Scroll RAM write enable |
| vsram_addr_o | output | 6 | Scroll RAM word address |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions take for granted that `vram_rd_data_i` is valid in the cycle after `vram_rd_o` and holds steady until the next read. They also assume that `sys_data_i` is valid whenever `sys_ack_i` is high, and that `sys_ack_i` rises only while `sys_req_o` is high. The stimulus keeps to this by driving both answers shortly after the rising edge, from the request outputs the design is showing. It stalls the acknowledge on a repeating pattern, so that waits of one and two cycles both occur. Start pulses with other parameters are sent while an operation is running, which exercises the rule that a busy engine ignores them.

// File: rtl/vdma_pkg.sv
// Package: shared types for the video memory block-transfer engine.
// Assumes: nothing beyond IEEE 1800-2017.
package vdma_pkg;

    // Destination selector for system-mode transfers.
    typedef enum logic [1:0] {
        TGT_VRAM  = 2'd0,
        TGT_CRAM  = 2'd1,
        TGT_VSRAM = 2'd2,
        TGT_NONE  = 2'd3
    } tgt_e;

    // Operation kind latched at start.
    typedef enum logic [1:0] {
        K_SYS  = 2'd0,
        K_FILL = 2'd1,
        K_COPY = 2'd2
    } kind_e;

    // Sequencer states.
    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_FILL_WAIT = 3'd1,
        ST_FILL      = 3'd2,
        ST_SYS       = 3'd3,
        ST_CP_RD     = 3'd4,
        ST_CP_WR     = 3'd5
    } st_e;

endpackage

// File: rtl/vdma_src_ctr.sv
// Module: source address counter made of three segments.
// The low segment counts once per step, and its wrap carries into the middle
// segment. The high segment is loaded at start and then left alone.
// Assumes: load and step are never high in the same cycle.
module vdma_src_ctr #(
    parameter int SEG_W = 8,
    parameter int HI_W  = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [SEG_W-1:0] lo_i,
    input  logic [SEG_W-1:0] mid_i,
    input  logic [HI_W-1:0]  hi_i,
    output logic [SEG_W-1:0] lo_o,
    output logic [SEG_W-1:0] mid_o,
    output logic [HI_W-1:0]  hi_o
);
    logic [SEG_W-1:0] lo_q, mid_q;
    logic [HI_W-1:0]  hi_q;
    logic             lo_wrap;

    assign lo_wrap = (lo_q == {SEG_W{1'b1}});

    // Load segments at start, then count the low segment with carry into middle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q  <= '0;
            mid_q <= '0;
            hi_q  <= '0;
        end else if (load) begin
            lo_q  <= lo_i;
            mid_q <= mid_i;
            hi_q  <= hi_i;
        end else if (step) begin
            lo_q <= lo_q + 1'b1;
            if (lo_wrap)
                mid_q <= mid_q + 1'b1;
        end
    end

    assign lo_o  = lo_q;
    assign mid_o = mid_q;
    assign hi_o  = hi_q;

    assert_hi_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(hi_q));
    assert_mid_carry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && !lo_wrap) |=> $stable(mid_q));

endmodule

// File: rtl/vdma_len_ctr.sv
// Module: transfer length counter.
// It counts down once per step. The step taken when one transfer remains is
// the last. A loaded zero therefore runs the full 2^LEN_W transfers.
// Assumes: load and step are never high in the same cycle.
module vdma_len_ctr #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [LEN_W-1:0] len_i,
    output logic             last_o
);
    logic [LEN_W-1:0] cnt_q;

    // Load the length at start, decrement once per transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= len_i;
        else if (step)
            cnt_q <= cnt_q - 1'b1;
    end

    assign last_o = (cnt_q == LEN_W'(1));

    assert_count_down_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (cnt_q == LEN_W'($past(cnt_q) - 1'b1)));

endmodule

// File: rtl/vdma_lane.sv
// Module: byte-lane steering and destination decode.
// It picks the write data, the lane enables and the target RAM from the
// operation kind and the parity of the destination address.
// Assumes: purely combinational; write qualification happens in the caller.
module vdma_lane
    import vdma_pkg::*;
(
    input  kind_e       kind,
    input  tgt_e        tgt,
    input  logic        addr_odd,
    input  logic [15:0] sys_data,
    input  logic [7:0]  byte_data,
    output logic [15:0] wdata,
    output logic [1:0]  be,
    output logic        hit_vram,
    output logic        hit_cram,
    output logic        hit_vsram
);
    // Steer data and lanes for each kind of transfer.
    always_comb begin
        wdata     = sys_data;
        be        = 2'b00;
        hit_vram  = 1'b0;
        hit_cram  = 1'b0;
        hit_vsram = 1'b0;
        unique case (kind)
            K_SYS: begin
                be = 2'b11;
                unique case (tgt)
                    TGT_VRAM:  hit_vram  = !addr_odd;
                    TGT_CRAM:  hit_cram  = 1'b1;
                    TGT_VSRAM: hit_vsram = 1'b1;
                    default:   ;
                endcase
            end
            K_COPY: begin
                wdata    = {byte_data, byte_data};
                be       = addr_odd ? 2'b01 : 2'b10;
                hit_vram = 1'b1;
            end
            K_FILL: begin
                wdata    = {byte_data, byte_data};
                be       = addr_odd ? 2'b10 : 2'b01;
                hit_vram = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/vdma_engine.sv
// Module: video memory block-transfer engine (top).
// It sequences system-to-video, copy and fill operations over a shared
// destination address, source counter and length counter.
// Assumes: read data arrives with sys_ack_i; a copy-mode read byte is valid
// in the cycle after vram_rd_o and held until the next read.
module vdma_engine
    import vdma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 16,
    parameter int SEG_W  = 8,
    parameter int HI_W   = 7,
    parameter int INC_W  = 8,
    parameter int PAL_AW = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [1:0]            mode_i,
    input  logic [1:0]            target_i,
    input  logic [ADDR_W-1:0]     dest_addr_i,
    input  logic [INC_W-1:0]      incr_i,
    input  logic [SEG_W-1:0]      src_lo_i,
    input  logic [SEG_W-1:0]      src_mid_i,
    input  logic [HI_W-1:0]       src_hi_i,
    input  logic [LEN_W-1:0]      len_i,
    input  logic                  fill_wr_i,
    input  logic [7:0]            fill_data_i,
    output logic                  sys_req_o,
    output logic [HI_W+2*SEG_W:0] sys_addr_o,
    input  logic                  sys_ack_i,
    input  logic [15:0]           sys_data_i,
    output logic                  vram_rd_o,
    output logic [2*SEG_W-1:0]    vram_rd_addr_o,
    input  logic [7:0]            vram_rd_data_i,
    output logic                  vram_we_o,
    output logic [ADDR_W-2:0]     vram_waddr_o,
    output logic [1:0]            vram_be_o,
    output logic [15:0]           wdata_o,
    output logic                  cram_we_o,
    output logic [PAL_AW-1:0]     cram_addr_o,
    output logic                  vsram_we_o,
    output logic [PAL_AW-1:0]     vsram_addr_o,
    output logic                  busy_o,
    output logic                  done_o
);
    st_e               st_q, st_d;
    kind_e             kind_q, kind_d;
    tgt_e              tgt_q;
    logic [ADDR_W-1:0] addr_q;
    logic [INC_W-1:0]  incr_q;
    logic [7:0]        fill_q;
    logic              done_q;
    logic              load, step, wr_phase, last;
    logic [SEG_W-1:0]  lo, mid;
    logic [HI_W-1:0]   hi;
    logic [7:0]        byte_data;
    logic [15:0]       lane_wdata;
    logic [1:0]        lane_be;
    logic              hit_vram, hit_cram, hit_vsram;

    // Decode the requested mode into an operation kind.
    always_comb begin
        if (!mode_i[1])      kind_d = K_SYS;
        else if (!mode_i[0]) kind_d = K_FILL;
        else                 kind_d = K_COPY;
    end

    assign load     = (st_q == ST_IDLE) && start_i;
    assign wr_phase = ((st_q == ST_SYS) && sys_ack_i) || (st_q == ST_CP_WR) || (st_q == ST_FILL);
    assign step     = wr_phase;

    vdma_src_ctr #(.SEG_W(SEG_W), .HI_W(HI_W)) src_i (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step),
        .lo_i(src_lo_i), .mid_i(src_mid_i), .hi_i(src_hi_i),
        .lo_o(lo), .mid_o(mid), .hi_o(hi)
    );

    vdma_len_ctr #(.LEN_W(LEN_W)) len_i_ctr (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step),
        .len_i(len_i), .last_o(last)
    );

    // Choose the next sequencer state.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:
                if (start_i) begin
                    unique case (kind_d)
                        K_SYS:   st_d = ST_SYS;
                        K_FILL:  st_d = ST_FILL_WAIT;
                        default: st_d = ST_CP_RD;
                    endcase
                end
            ST_FILL_WAIT: if (fill_wr_i) st_d = ST_FILL;
            ST_FILL:      if (last) st_d = ST_IDLE;
            ST_SYS:       if (sys_ack_i && last) st_d = ST_IDLE;
            ST_CP_RD:     st_d = ST_CP_WR;
            ST_CP_WR:     st_d = last ? ST_IDLE : ST_CP_RD;
            default:      st_d = ST_IDLE;
        endcase
    end

    // Hold the state, the latched operation and the completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            kind_q <= K_SYS;
            tgt_q  <= TGT_VRAM;
            addr_q <= '0;
            incr_q <= '0;
            fill_q <= '0;
            done_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            done_q <= step && last;
            if (load) begin
                kind_q <= kind_d;
                tgt_q  <= tgt_e'(target_i);
                addr_q <= dest_addr_i;
                incr_q <= incr_i;
            end else if (step) begin
                addr_q <= addr_q + ADDR_W'(incr_q);
            end
            if ((st_q == ST_FILL_WAIT) && fill_wr_i)
                fill_q <= fill_data_i;
        end
    end

    assign byte_data = (kind_q == K_COPY) ? vram_rd_data_i : fill_q;

    vdma_lane lane_i (
        .kind(kind_q), .tgt(tgt_q), .addr_odd(addr_q[0]),
        .sys_data(sys_data_i), .byte_data(byte_data),
        .wdata(lane_wdata), .be(lane_be),
        .hit_vram(hit_vram), .hit_cram(hit_cram), .hit_vsram(hit_vsram)
    );

    assign sys_req_o      = (st_q == ST_SYS);
    assign sys_addr_o     = {hi, mid, lo, 1'b0};
    assign vram_rd_o      = (st_q == ST_CP_RD);
    assign vram_rd_addr_o = {mid, lo};
    assign vram_we_o      = wr_phase && hit_vram;
    assign cram_we_o      = wr_phase && hit_cram;
    assign vsram_we_o     = wr_phase && hit_vsram;
    assign vram_waddr_o   = addr_q[ADDR_W-1:1];
    assign cram_addr_o    = addr_q[PAL_AW:1];
    assign vsram_addr_o   = addr_q[PAL_AW:1];
    assign vram_be_o      = lane_be;
    assign wdata_o        = lane_wdata;
    assign busy_o         = (st_q != ST_IDLE);
    assign done_o         = done_q;

    assert_single_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({vram_we_o, cram_we_o, vsram_we_o}));
    assert_odd_skip_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (vram_we_o && kind_q == K_SYS) |-> !addr_q[0]);
    assert_one_lane_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (vram_we_o && kind_q != K_SYS) |-> ($countones(vram_be_o) == 1));
    assert_addr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (addr_q == ADDR_W'($past(addr_q) + ADDR_W'($past(incr_q)))));
    assert_fill_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_FILL_WAIT) |-> !vram_we_o);
    assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);
    assert_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(incr_q));

endmodule

// File: tb/vdma_engine_tb_top.sv
module vdma_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  mode_i = '0;
    logic [1:0]  target_i = '0;
    logic [15:0] dest_addr_i = '0;
    logic [7:0]  incr_i = '0;
    logic [7:0]  src_lo_i = '0, src_mid_i = '0;
    logic [6:0]  src_hi_i = '0;
    logic [15:0] len_i = '0;
    logic        fill_wr_i = 1'b0;
    logic [7:0]  fill_data_i = '0;
    logic        sys_req_o;
    logic [23:0] sys_addr_o;
    logic        sys_ack_i = 1'b0;
    logic [15:0] sys_data_i = '0;
    logic        vram_rd_o;
    logic [15:0] vram_rd_addr_o;
    logic [7:0]  vram_rd_data_i = '0;
    logic        vram_we_o;
    logic [14:0] vram_waddr_o;
    logic [1:0]  vram_be_o;
    logic [15:0] wdata_o;
    logic        cram_we_o;
    logic [5:0]  cram_addr_o;
    logic        vsram_we_o;
    logic [5:0]  vsram_addr_o;
    logic        busy_o, done_o;

    int vecs = 0;
    int errs = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    vdma_engine dut_i (.*);

    function automatic logic [15:0] sys_word(input logic [23:0] a);
        return a[16:1] ^ 16'h3C96 ^ {8'h00, a[23:16]};
    endfunction

    function automatic logic [7:0] vbyte(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Responders: answer requests shortly after the rising edge.
    initial begin
        logic [1:0] tick = '0;
        forever begin
            @(posedge clk);
            #1;
            tick = tick + 1'b1;
            sys_ack_i  = sys_req_o && (tick != 2'd0);
            sys_data_i = sys_word(sys_addr_o);
            if (vram_rd_o)
                vram_rd_data_i = vbyte(vram_rd_addr_o);
        end
    end

    // Watchdog.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000) begin
                errs++;
                $display("FAIL watchdog actual=%0d expected<190000", cycles);
                $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
                $finish;
            end
        end
    end

    // Run one operation and check every transfer against a bench model.
    // mode: 0 system, 2 fill, 3 copy. poke: send a stray start while busy.
    task automatic run_op(input logic [1:0] mode, input logic [1:0] tgt,
                          input logic [15:0] dest, input logic [7:0] inc,
                          input logic [7:0] lo, input logic [7:0] mid, input logic [6:0] hi,
                          input logic [15:0] len, input logic [7:0] fb, input bit poke);
        logic [15:0] ea = dest;
        logic [7:0]  elo = lo, emid = mid;
        int steps = 0;
        int total = (len == 0) ? 65536 : int'(len);
        int waitc = 0;
        bit fin = 0;
        @(negedge clk);
        start_i = 1; mode_i = mode; target_i = tgt; dest_addr_i = dest; incr_i = inc;
        src_lo_i = lo; src_mid_i = mid; src_hi_i = hi; len_i = len;
        @(negedge clk);
        start_i = 0;
        chk(busy_o == 1'b1, "R10 busy after start", busy_o, 1);
        if (mode == 2'b10) begin
            for (int i = 0; i < 4; i++) begin
                chk(!vram_we_o && busy_o, "R9 no fill before data", vram_we_o, 0);
                @(negedge clk);
            end
            fill_wr_i = 1; fill_data_i = fb;
            @(negedge clk);
            fill_wr_i = 0;
        end
        while (!fin) begin
            waitc++;
            if (poke && waitc == 3) begin
                start_i = 1; mode_i = 2'b10; incr_i = 8'h77; dest_addr_i = 16'h1111;
            end else begin
                start_i = 0;
            end
            if (done_o) begin
                fin = 1;
                chk(!busy_o, "R10 busy low at done", busy_o, 0);
                chk(steps == total, "R8 transfer count", steps, total);
            end else begin
                if (mode[1] == 1'b0 && sys_req_o && sys_ack_i) begin
                    chk(sys_addr_o == {hi, emid, elo, 1'b0}, "R2 source address", sys_addr_o, {hi, emid, elo, 1'b0});
                    case (tgt)
                        2'd0: if (ea[0])
                                  chk(!vram_we_o && !cram_we_o && !vsram_we_o, "R4 odd word dropped", vram_we_o, 0);
                              else
                                  chk(vram_we_o && vram_waddr_o == ea[15:1] && vram_be_o == 2'b11 &&
                                      wdata_o == sys_word({hi, emid, elo, 1'b0}), "R3 video word", wdata_o,
                                      sys_word({hi, emid, elo, 1'b0}));
                        2'd1: chk(cram_we_o && !vram_we_o && cram_addr_o == ea[6:1] &&
                                  wdata_o == sys_word({hi, emid, elo, 1'b0}), "R3 colour write", cram_addr_o, ea[6:1]);
                        default: chk(vsram_we_o && !vram_we_o && vsram_addr_o == ea[6:1] &&
                                  wdata_o == sys_word({hi, emid, elo, 1'b0}), "R3 scroll write", vsram_addr_o, ea[6:1]);
                    endcase
                    steps++;
                end
                if (mode == 2'b11 && vram_rd_o)
                    chk(vram_rd_addr_o == {emid, elo}, "R5 copy source", vram_rd_addr_o, {emid, elo});
                if (mode[1] && vram_we_o) begin
                    logic [7:0] b = (mode == 2'b11) ? vbyte({emid, elo}) : fb;
                    logic [1:0] ebe = ((mode == 2'b11) ^ ea[0]) ? 2'b10 : 2'b01;
                    if (mode == 2'b11)
                        chk(vram_be_o == ebe && wdata_o == {b, b}, "R5 copy lane", {vram_be_o, wdata_o}, {ebe, b, b});
                    else
                        chk(vram_be_o == ebe && wdata_o == {b, b}, "R6 fill lane", {vram_be_o, wdata_o}, {ebe, b, b});
                    chk(vram_waddr_o == ea[15:1], "R7 destination address", vram_waddr_o, ea[15:1]);
                    steps++;
                end
                if (steps > 0 && (sys_ack_i && sys_req_o || mode[1] && vram_we_o)) begin
                    ea = ea + {8'h00, inc};
                    elo = elo + 1'b1;
                    if (elo == 8'h00) emid = emid + 1'b1;
                end
            end
            if (!fin) @(negedge clk);
        end
        start_i = 0;
        @(negedge clk);
        chk(!done_o, "R10 done one cycle", done_o, 0);
        if (poke)
            chk(!busy_o && !vram_we_o, "R11 stray start ignored", busy_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy_o && !done_o && !sys_req_o && !vram_rd_o && !vram_we_o && !cram_we_o && !vsram_we_o,
            "R1 reset outputs", {busy_o, done_o, sys_req_o, vram_we_o}, 0);
        rst_n = 1;
        @(negedge clk);
        chk(!busy_o && !done_o, "R1 idle after reset", busy_o, 0);
        for (int inc = 1; inc <= 3; inc++) begin
            for (int d = 0; d < 2; d++) begin
                run_op(2'b00, 2'd0, 16'h2400 + 16'(d), 8'(inc), 8'hFD, 8'hFF, 7'h5A, 16'd5, 8'h00, 0);
                run_op(2'b11, 2'd0, 16'h1000 + 16'(d), 8'(inc), 8'hFE, 8'h12, 7'h00, 16'd6, 8'h00, 0);
                run_op(2'b10, 2'd0, 16'h3000 + 16'(d), 8'(inc), 8'h00, 8'h00, 7'h00, 16'd7, 8'hC3, 0);
            end
        end
        run_op(2'b00, 2'd1, 16'h0000, 8'd2, 8'h10, 8'h00, 7'h01, 16'd40, 8'h00, 0);
        run_op(2'b01, 2'd2, 16'h0004, 8'd2, 8'hF0, 8'h33, 7'h7F, 16'd20, 8'h00, 0);
        run_op(2'b10, 2'd0, 16'hFFFE, 8'd3, 8'h00, 8'h00, 7'h00, 16'd4, 8'h9E, 0);
        run_op(2'b00, 2'd0, 16'h0100, 8'd2, 8'h00, 8'h01, 7'h02, 16'd12, 8'h00, 1);
        run_op(2'b10, 2'd0, 16'h0001, 8'd1, 8'h00, 8'h00, 7'h00, 16'd0, 8'h4B, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule